// File: doc/BRIEF.md
# Four-Channel Periodic Down-Counter Timer

This block holds a set of independent down-counting timer channels behind a small word-addressed register port. Each channel counts down from a programmed load value. When it passes zero it raises a sticky expiry flag and reloads, so every channel runs periodically until software turns it off. Each channel drives its own interrupt line, which is high while the channel's flag and its interrupt-enable bit are both set.

A global halt bit in the module control word freezes every channel. The block leaves reset with that bit set, so software first programs the channels and then clears the bit. A channel above channel 0 can be cascaded onto the channel below it. It then steps once per expiry of its neighbour rather than once per clock, and a pair of channels becomes one 64-bit counter.

Writes take effect on the clock edge that samples `wr_en`. Read data is a combinational function of `addr`.

Top module: `pit_timer_array`

## Requirements
- R1: Reset sets the halt bit (bit 1 of the word at 0x000) to 1. It clears every load, control and flag register and drives every interrupt line low.
- R2: Register map, using word-aligned addresses only. 0x000 is the module control word, with halt in bit 1. Channel n starts at 0x100+0x10*n and holds four words: load value (+0x0), live count (+0x4, read-only), control (+0x8) and flag (+0xC). Control reads back only bits [2:0]: run in bit 0, interrupt-enable in bit 1, cascade in bit 2. The module control word reads back only bit 1. Unmapped or misaligned addresses read 0, and writes to them change nothing.
- R3: The first clock edge after a channel's run bit goes from 0 to 1 loads its count from the load value. After that the count falls by one per clock.
- R4: A running channel with load value L has an expiry period of L+1 clocks. The flag sets on the same edge that reloads the count with L, and counting carries on with no stop.
- R5: The flag stays set until software writes a 1 to bit 0 of the flag word. Writing 0 to that bit leaves the flag as it is.
- R6: Each channel's interrupt line equals its flag AND its interrupt-enable bit.
- R7: Writing the load value while a channel runs does not disturb the count in progress. The new value is used at the next reload. Clearing the run bit and setting it again restarts the count from the new value.
- R8: While the halt bit is 1, no channel's count changes.
- R9: When channel n>0 has its cascade bit set, its count changes only on clocks in which channel n-1 expires.
- R10: The cascade bit has no effect on channel 0, which keeps counting once per clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counter and register clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for `addr`/`wdata` |
| addr | input | ADDR_W (12) | Byte address for reads and writes |
| wdata | input | DW (32) | Write data |
| rdata | output | DW (32) | Read data for `addr` (combinational) |
| irq | output | NCH (4) | Per-channel interrupt lines |

## Verification
The bench times the first expiry against the exact cycle count of L+2 edges after the enable write, then the L+1 spacing of later expiries. A design off by one would shift the flag sampling point by one edge. It rewrites the load value in mid-cycle and confirms that the running count reaches zero and only then picks up the new value; a design that restarted on the write would show the new value at once. It checks that a halt freezes the count and that clearing the halt lets it resume. It also checks that a cascaded channel holds its count across the gaps between lower-channel expiries, which fails if the cascade gating is missing. Finally, it checks that writes of 0 to the flag, writes to misaligned addresses and the cascade bit on channel 0 change nothing that can be observed.

// File: rtl/pit_pkg.sv
package pit_pkg;

    localparam int unsigned MCR_ADDR  = 'h000;
    localparam int unsigned CH_BASE   = 'h100;
    localparam int unsigned CH_STRIDE = 'h010;
    localparam int unsigned HALT_BIT  = 1;
    localparam int unsigned CTL_W     = 3;

    typedef struct packed {
        logic cascade;
        logic irq_en;
        logic run;
    } chan_ctl_t;

    typedef enum logic [2:0] {
        RK_NONE,
        RK_MCR,
        RK_LOAD,
        RK_COUNT,
        RK_CTRL,
        RK_FLAG
    } rd_kind_e;

    function automatic rd_kind_e word_kind(input logic [1:0] w);
        case (w)
            2'd0:    return RK_LOAD;
            2'd1:    return RK_COUNT;
            2'd2:    return RK_CTRL;
            default: return RK_FLAG;
        endcase
    endfunction

endpackage

// File: rtl/pit_regdec.sv
module pit_regdec
    import pit_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int ADDR_W = 12,
    localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    output logic              mcr_we,
    output logic [NCH-1:0]    ld_we,
    output logic [NCH-1:0]    ctl_we,
    output logic [NCH-1:0]    flg_we,
    output rd_kind_e          rd_kind,
    output logic [CH_W-1:0]   rd_ch
);
    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(CH_BASE);
    localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(CH_STRIDE * NCH);
    localparam logic [ADDR_W-1:0] MCR  = ADDR_W'(MCR_ADDR);

    logic [ADDR_W-1:0] rel;
    logic              aligned;

    always_comb begin
        rel     = addr - BASE;
        aligned = (addr[1:0] == 2'b00);
        rd_ch   = rel[CH_W+3:4];
        if (aligned && addr == MCR)
            rd_kind = RK_MCR;
        else if (aligned && rel < SPAN)
            rd_kind = word_kind(rel[3:2]);
        else
            rd_kind = RK_NONE;

        mcr_we = wr_en && (rd_kind == RK_MCR);
        for (int i = 0; i < NCH; i++) begin
            ld_we[i]  = wr_en && (rd_ch == CH_W'(i)) && (rd_kind == RK_LOAD);
            ctl_we[i] = wr_en && (rd_ch == CH_W'(i)) && (rd_kind == RK_CTRL);
            flg_we[i] = wr_en && (rd_ch == CH_W'(i)) && (rd_kind == RK_FLAG);
        end
    end
endmodule

// File: rtl/pit_chan.sv
module pit_chan
    import pit_pkg::*;
#(
    parameter int DW       = 32,
    parameter bit CASC_OK  = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          halt,
    input  logic          ld_we,
    input  logic          ctl_we,
    input  logic          flg_we,
    input  logic [DW-1:0] wdata,
    input  logic          below_exp,
    output logic [DW-1:0] ldval,
    output logic [DW-1:0] cnt,
    output chan_ctl_t     ctl,
    output logic          flag,
    output logic          armed,
    output logic          expire,
    output logic          irq
);
    logic step;

    always_comb begin
        step   = (CASC_OK && ctl.cascade) ? below_exp : 1'b1;
        expire = !halt && ctl.run && armed && step && (cnt == '0);
        irq    = flag && ctl.irq_en;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ldval <= '0;
            ctl   <= '0;
            flag  <= 1'b0;
            armed <= 1'b0;
        end else begin
            if (ld_we)
                ldval <= wdata;
            if (ctl_we)
                ctl <= chan_ctl_t'(wdata[CTL_W-1:0]);
            if (expire)
                flag <= 1'b1;
            else if (flg_we && wdata[0])
                flag <= 1'b0;
            if (!halt)
                armed <= ctl.run;
        end
    end

    // live count is deliberately left out of reset
    always_ff @(posedge clk) begin
        if (!rst && !halt && ctl.run) begin
            if (!armed)
                cnt <= ldval;
            else if (step)
                cnt <= (cnt == '0) ? ldval : cnt - 1'b1;
        end
    end
endmodule

// File: rtl/pit_timer_array.sv
module pit_timer_array
    import pit_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int ADDR_W = 12,
    parameter int DW     = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    output logic [NCH-1:0]    irq
);
    localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1;

    logic                  mcr_we;
    logic [NCH-1:0]        ld_we, ctl_we, flg_we;
    rd_kind_e              rd_kind;
    logic [CH_W-1:0]       rd_ch;
    logic                  mcr_halt;

    logic [NCH-1:0][DW-1:0] ld_v;
    logic [NCH-1:0][DW-1:0] cnt_v;
    chan_ctl_t [NCH-1:0]    ctl_v;
    logic [NCH-1:0]         flag_v, armed_v, exp_v, chain_v, run_v;

    pit_regdec #(.NCH(NCH), .ADDR_W(ADDR_W)) u_dec (
        .addr(addr), .wr_en(wr_en), .mcr_we(mcr_we),
        .ld_we(ld_we), .ctl_we(ctl_we), .flg_we(flg_we),
        .rd_kind(rd_kind), .rd_ch(rd_ch)
    );

    always_ff @(posedge clk) begin
        if (rst)
            mcr_halt <= 1'b1;
        else if (mcr_we)
            mcr_halt <= wdata[HALT_BIT];
    end

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic below;
        if (g == 0) begin : g_first
            assign below = 1'b0;
        end else begin : g_upper
            assign below = exp_v[g-1];
        end

        pit_chan #(.DW(DW), .CASC_OK(g != 0)) u_chan (
            .clk(clk), .rst(rst), .halt(mcr_halt),
            .ld_we(ld_we[g]), .ctl_we(ctl_we[g]), .flg_we(flg_we[g]),
            .wdata(wdata), .below_exp(below),
            .ldval(ld_v[g]), .cnt(cnt_v[g]), .ctl(ctl_v[g]),
            .flag(flag_v[g]), .armed(armed_v[g]), .expire(exp_v[g]),
            .irq(irq[g])
        );

        assign chain_v[g] = ctl_v[g].cascade;
        assign run_v[g]   = ctl_v[g].run;
    end

    always_comb begin
        unique case (rd_kind)
            RK_MCR:   rdata = DW'({mcr_halt, 1'b0});
            RK_LOAD:  rdata = ld_v[rd_ch];
            RK_COUNT: rdata = cnt_v[rd_ch];
            RK_CTRL:  rdata = DW'(ctl_v[rd_ch]);
            RK_FLAG:  rdata = DW'(flag_v[rd_ch]);
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/pit_timer_chk.sv
module pit_timer_chk #(
    parameter int NCH = 4,
    parameter int DW  = 32
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  halt,
    input logic [NCH-1:0][DW-1:0] cnt,
    input logic [NCH-1:0][DW-1:0] ldval,
    input logic [NCH-1:0]        flag,
    input logic [NCH-1:0]        expire,
    input logic [NCH-1:0]        chain,
    input logic [NCH-1:0]        run,
    input logic [NCH-1:0]        armed,
    input logic [NCH-1:0]        flg_we,
    input logic [DW-1:0]         wdata,
    input logic [NCH-1:0]        irq
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (irq == '0 && halt));

    for (genvar g = 0; g < NCH; g++) begin : g_a
        // R8
        halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
            halt |=> $stable(cnt[g]));

        // R4
        reload_flag_chk: assert property (@(posedge clk) disable iff (rst)
            expire[g] |=> (flag[g] && cnt[g] == $past(ldval[g])));

        // R5
        flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
            $fell(flag[g]) |-> $past(flg_we[g] && wdata[0]));

        if (g > 0) begin : g_casc
            // R9
            cascade_gate_chk: assert property (@(posedge clk) disable iff (rst)
                (!halt && chain[g] && run[g] && armed[g] && !expire[g-1])
                |=> $stable(cnt[g]));
        end
    end
endmodule

bind pit_timer_array pit_timer_chk #(.NCH(NCH), .DW(DW)) u_chk (
    .clk(clk), .rst(rst), .halt(mcr_halt), .cnt(cnt_v), .ldval(ld_v),
    .flag(flag_v), .expire(exp_v), .chain(chain_v), .run(run_v),
    .armed(armed_v), .flg_we(flg_we), .wdata(wdata), .irq(irq)
);

// File: tb/tb_pit_timer_array.sv
module tb_pit_timer_array;
    localparam int NCH = 4;
    localparam int AW  = 12;
    localparam int DW  = 32;
    localparam int WATCHDOG = 20000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic [NCH-1:0] irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pit_timer_array #(.NCH(NCH), .ADDR_W(AW), .DW(DW)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    typedef struct packed {
        logic [AW-1:0] a;
        logic [DW-1:0] d;
        logic [DW-1:0] e;
    } vec_t;

    // write d to a, read a back, expect e (R2)
    localparam vec_t VEC [10] = '{
        '{12'h100, 32'hDEADBEEF, 32'hDEADBEEF},
        '{12'h110, 32'h12345678, 32'h12345678},
        '{12'h120, 32'hFFFFFFFF, 32'hFFFFFFFF},
        '{12'h130, 32'h00000007, 32'h00000007},
        '{12'h128, 32'hFFFFFFFA, 32'h00000002},
        '{12'h138, 32'h00000004, 32'h00000004},
        '{12'h11C, 32'h00000001, 32'h00000000},
        '{12'h140, 32'hFFFFFFFF, 32'h00000000},
        '{12'h102, 32'h00000055, 32'h00000000},
        '{12'h000, 32'hFFFFFFFD, 32'h00000000}
    };

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic chk(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic chk_rd(input string tag, input logic [AW-1:0] a, input logic [DW-1:0] exp);
        logic [DW-1:0] v;
        rd(a, v);
        chk(tag, v, exp);
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        step(3);
        rst = 1'b0;
        #1;
        // R1 reset state
        chk_rd("R1 halt", 12'h000, 32'h2);
        chk_rd("R1 load0", 12'h100, 32'h0);
        chk_rd("R1 ctrl0", 12'h108, 32'h0);
        chk_rd("R1 flag0", 12'h10C, 32'h0);
        chk("R1 irq", DW'(irq), 32'h0);

        // R2 register table
        for (int i = 0; i < 10; i++) begin
            wr(VEC[i].a, VEC[i].d);
            chk_rd("R2 table", VEC[i].a, VEC[i].e);
        end
        chk_rd("R2 misaligned write ignored", 12'h100, 32'hDEADBEEF);
        wr(12'h128, 32'h0);
        wr(12'h138, 32'h0);

        // R3/R4 period with L=4
        wr(12'h100, 32'd4);
        wr(12'h108, 32'h3);                       // E0
        step(1); chk_rd("R3 load on enable", 12'h104, 32'd4);
        step(1); chk_rd("R3 decrement", 12'h104, 32'd3);
        step(3); chk_rd("R4 no flag before L+2", 12'h10C, 32'h0);
        step(1); chk_rd("R4 flag at reload", 12'h10C, 32'h1);   // E6
        chk_rd("R4 reload value", 12'h104, 32'd4);
        chk("R6 irq with ie", DW'(irq[0]), 32'h1);
        step(5); chk_rd("R4 keeps running", 12'h104, 32'd4);    // E11
        wr(12'h10C, 32'h0);                       // E12
        chk_rd("R5 write 0 keeps flag", 12'h10C, 32'h1);
        wr(12'h10C, 32'h1);                       // E13
        chk_rd("R5 write 1 clears", 12'h10C, 32'h0);
        chk("R6 irq low after clear", DW'(irq[0]), 32'h0);
        step(2); chk_rd("R4 period before", 12'h10C, 32'h0);    // E15
        step(1); chk_rd("R4 period L+1", 12'h10C, 32'h1);       // E16

        // R6 interrupt enable gating
        wr(12'h108, 32'h1);                       // E17
        chk("R6 irq masked", DW'(irq[0]), 32'h0);
        wr(12'h108, 32'h3);                       // E18
        chk("R6 irq unmasked", DW'(irq[0]), 32'h1);

        // R7 load write mid-run
        wr(12'h100, 32'd9);                       // E19
        step(1); chk_rd("R7 no restart on load write", 12'h104, 32'd0);  // E20
        step(1); chk_rd("R7 new value at reload", 12'h104, 32'd9);       // E21
        wr(12'h108, 32'h0);                       // E22
        wr(12'h100, 32'd2);                       // E23
        wr(12'h108, 32'h3);                       // E24
        step(1); chk_rd("R7 restart after re-enable", 12'h104, 32'd2);   // E25

        // R8 halt freezes counting
        wr(12'h000, 32'h2);                       // E26
        chk_rd("R8 count at halt", 12'h104, 32'd1);
        step(3); chk_rd("R8 frozen", 12'h104, 32'd1);
        wr(12'h000, 32'h0);                       // E30
        chk_rd("R8 still frozen on release edge", 12'h104, 32'd1);
        step(1); chk_rd("R8 resumes", 12'h104, 32'd0);

        wr(12'h108, 32'h0);
        wr(12'h10C, 32'h1);

        // R9 cascade channel 1 onto channel 0
        wr(12'h110, 32'd2);
        wr(12'h118, 32'h5);
        wr(12'h100, 32'd3);
        wr(12'h108, 32'h1);                       // Ea
        step(4); chk_rd("R9 holds between lower expiries", 12'h114, 32'd2);
        step(1); chk_rd("R9 steps on lower expiry", 12'h114, 32'd1);
        step(7); chk_rd("R9 count zero", 12'h114, 32'd0);
        chk_rd("R9 no flag yet", 12'h11C, 32'h0);
        step(1); chk_rd("R9 flag after L+1 lower expiries", 12'h11C, 32'h1);
        chk_rd("R9 reload", 12'h114, 32'd2);

        // R10 cascade bit on channel 0
        wr(12'h108, 32'h0);
        wr(12'h100, 32'd5);
        wr(12'h108, 32'h5);
        step(1); chk_rd("R10 load", 12'h104, 32'd5);
        step(1); chk_rd("R10 counts per clock", 12'h104, 32'd4);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule